// File: doc/BRIEF.md
# Instrument Status Group

This block is one status group of an instrument. A vector of condition inputs is sampled once per clock. Each bit runs through a per-bit edge filter that can catch rising edges, falling edges, or both. A caught edge sets a sticky bit in the event register. The event bits are masked by an enable register and OR-reduced to a single summary output. That output feeds whatever aggregates status above the group.

Software reaches the group through a small synchronous register port. The rise mask, fall mask and enable register can be written and read. The condition register and the event register can only be read, and a read of the event register empties it.

Two extra controls act on the group:
- A clear-status strobe empties the event register and leaves every mask untouched.
- A device-reset strobe reloads every register with its default.

A two-state sampler (PRIME, RUN) guards against false edges. In PRIME it loads the current sample and the previous sample from the inputs and reports no edges. PRIME moves to RUN on the next clock unless device reset is still high. RUN returns to PRIME whenever device reset is asserted. Power-up reset also enters PRIME.

Top module: `status_group`

## Requirements
- R1: After power-up reset the register port reads as follows: rise mask all ones, fall mask zero, enable zero, event zero, and the summary is low. Register addresses are: 0 condition, 1 event, 2 enable, 3 rise mask, 4 fall mask. Addresses 5 to 7 read zero, and rdata is zero while rd_en is low.
- R2: A condition bit that goes from 0 to 1 while its rise-mask bit is 1 sets its event bit. The input is driven before clock edge k, the sample register takes it at edge k, and the event bit reads set after edge k+1.
- R3: A condition bit that goes from 1 to 0 while its fall-mask bit is 1 sets its event bit, with the same two-edge timing.
- R4: A bit armed in both masks captures edges in both directions. A bit armed in neither mask never sets its event bit.
- R5: Once set, an event bit stays set. Further qualifying edges on that bit have no further effect, and the bit clears only by an event read, clear-status or a reset.
- R6: A read of address 1 returns the event register in the same cycle and clears it at the following edge.
- R7: Clear-status empties the event register and leaves the rise mask, fall mask and enable register unchanged.
- R8: If a qualifying edge coincides with an event read or with clear-status, the bit is set after that cycle. A read in that cycle returns the old value.
- R9: Writes to addresses 0 and 1 change nothing.
- R10: The summary output equals the OR over all bits of (event AND enable). It is combinational from those registers.
- R11: Device reset loads the rise mask with all ones and the fall mask with zero, and clears the enable and event registers. It passes through PRIME, so inputs held high across the reset create no event.
- R12: Reads of the condition register, the masks and the enable register change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| cond_in | input | WIDTH | Raw condition inputs |
| dev_rst | input | 1 | Device-reset strobe |
| clr_stat | input | 1 | Clear-status strobe |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data, valid in the cycle of rd_en |
| summary | output | 1 | OR of enabled event bits |

## Verification
The bench builds the group with WIDTH = 8 and the default masks (rise all ones, fall zero). Eight lanes are enough to arm lanes rising-only, falling-only, both and neither at the same time. Random traffic then mixes edges with reads, writes, clear-status and device reset. That drives the coincidence cases of R8 and the PRIME re-entry of R11 many times, each compared against a reference model of the register file.

// File: rtl/sgrp_pkg.sv
package sgrp_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_COND      = 3'd0,
        A_EVENT     = 3'd1,
        A_ENABLE    = 3'd2,
        A_RISE_MASK = 3'd3,
        A_FALL_MASK = 3'd4
    } reg_addr_e;

    typedef enum logic {
        S_PRIME = 1'b0,
        S_RUN   = 1'b1
    } samp_state_e;
endpackage

// File: rtl/sgrp_sampler.sv
module sgrp_sampler import sgrp_pkg::*; #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dev_rst,
    input  logic [WIDTH-1:0] cond_in,
    output logic [WIDTH-1:0] cond_q,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    samp_state_e state, state_nxt;
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_PRIME;
        else        state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            S_PRIME: state_nxt = dev_rst ? S_PRIME : S_RUN;
            S_RUN:   state_nxt = dev_rst ? S_PRIME : S_RUN;
            default: state_nxt = S_PRIME;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= '0;
            prev_q <= '0;
        end else if (state == S_PRIME) begin
            cond_q <= cond_in;
            prev_q <= cond_in;
        end else begin
            cond_q <= cond_in;
            prev_q <= cond_q;
        end
    end

    always_comb begin
        unique case (state)
            S_RUN: begin
                rise = cond_q & ~prev_q;
                fall = ~cond_q & prev_q;
            end
            default: begin
                rise = '0;
                fall = '0;
            end
        endcase
    end

    // R11: leaving PRIME, both samples match, so no false edge
    p_prime_aligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PRIME) |=> (cond_q == prev_q));

    // R11: device reset always lands in PRIME
    p_devrst_prime_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst |=> (state == S_PRIME));

    // R2: a rise on a bit is reported for exactly one cycle
    p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/sgrp_events.sv
module sgrp_events #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dev_rst,
    input  logic             clr,
    input  logic [WIDTH-1:0] hit,
    output logic [WIDTH-1:0] evt
);
    logic [WIDTH-1:0] evt_nxt;

    always_comb begin
        if (dev_rst)  evt_nxt = '0;
        else if (clr) evt_nxt = hit;
        else          evt_nxt = evt | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt <= '0;
        else        evt <= evt_nxt;
    end

    // R5: set bits persist without a clear
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_rst && !clr) |=> ((evt & $past(evt)) == $past(evt)));

    // R8: a qualifying edge is never lost, even alongside a clear
    p_new_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_rst |=> ((evt & $past(hit)) == $past(hit)));

    // R7: a clear leaves only the bits hit in that cycle
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !dev_rst) |=> ((evt & ~$past(hit)) == '0));

    // R11: device reset empties the event register
    p_devrst_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst |=> (evt == '0));
endmodule

// File: rtl/sgrp_regs.sv
module sgrp_regs import sgrp_pkg::*; #(
    parameter int               WIDTH        = 8,
    parameter logic [WIDTH-1:0] RISE_DEFAULT = '1,
    parameter logic [WIDTH-1:0] FALL_DEFAULT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [WIDTH-1:0]  cond_q,
    input  logic [WIDTH-1:0]  evt,
    output logic [WIDTH-1:0]  rise_mask,
    output logic [WIDTH-1:0]  fall_mask,
    output logic [WIDTH-1:0]  enable,
    output logic [WIDTH-1:0]  rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_mask <= RISE_DEFAULT;
            fall_mask <= FALL_DEFAULT;
            enable    <= '0;
        end else if (dev_rst) begin
            rise_mask <= RISE_DEFAULT;
            fall_mask <= FALL_DEFAULT;
            enable    <= '0;
        end else if (wr_en) begin
            case (addr)
                A_ENABLE:    enable    <= wdata;
                A_RISE_MASK: rise_mask <= wdata;
                A_FALL_MASK: fall_mask <= wdata;
                default:     ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                A_COND:      rdata = cond_q;
                A_EVENT:     rdata = evt;
                A_ENABLE:    rdata = enable;
                A_RISE_MASK: rdata = rise_mask;
                A_FALL_MASK: rdata = fall_mask;
                default:     rdata = '0;
            endcase
        end
    end

    // R7, R12: without a write or device reset, configuration is stable
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !dev_rst) |=> ($stable(rise_mask) && $stable(fall_mask) && $stable(enable)));

    // R9: writes to read-only addresses leave configuration untouched
    p_ro_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !dev_rst && (addr == A_COND || addr == A_EVENT))
        |=> ($stable(rise_mask) && $stable(fall_mask) && $stable(enable)));
endmodule

// File: rtl/status_group.sv
module status_group import sgrp_pkg::*; #(
    parameter int               WIDTH        = 8,
    parameter logic [WIDTH-1:0] RISE_DEFAULT = '1,
    parameter logic [WIDTH-1:0] FALL_DEFAULT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  cond_in,
    input  logic              dev_rst,
    input  logic              clr_stat,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rdata,
    output logic              summary
);
    logic [WIDTH-1:0] cond_q, rise, fall, hit, evt;
    logic [WIDTH-1:0] rise_mask, fall_mask, enable;
    logic             clr_any;

    sgrp_sampler #(.WIDTH(WIDTH)) u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .dev_rst (dev_rst),
        .cond_in (cond_in),
        .cond_q  (cond_q),
        .rise    (rise),
        .fall    (fall)
    );

    assign hit     = (rise & rise_mask) | (fall & fall_mask);
    assign clr_any = clr_stat | (rd_en && (addr == A_EVENT));

    sgrp_events #(.WIDTH(WIDTH)) u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .dev_rst (dev_rst),
        .clr     (clr_any),
        .hit     (hit),
        .evt     (evt)
    );

    sgrp_regs #(
        .WIDTH        (WIDTH),
        .RISE_DEFAULT (RISE_DEFAULT),
        .FALL_DEFAULT (FALL_DEFAULT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_rst   (dev_rst),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .cond_q    (cond_q),
        .evt       (evt),
        .rise_mask (rise_mask),
        .fall_mask (fall_mask),
        .enable    (enable),
        .rdata     (rdata)
    );

    assign summary = |(evt & enable);

    // R10, R11: summary is low after a device reset
    p_summary_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst |=> !summary);

    // R10: summary cannot rise without an event and an enable both present
    p_summary_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(summary) |-> ((evt != '0) && (enable != '0)));
endmodule

// File: tb/status_group_tb.sv
module status_group_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] cond_in;
    logic         dev_rst, clr_stat, wr_en, rd_en;
    logic [2:0]   addr;
    logic [W-1:0] wdata;
    logic [W-1:0] rdata;
    logic         summary;

    int checks = 0;
    int failures = 0;

    // reference model
    logic [W-1:0] m_cq, m_pq, m_ptr, m_ntr, m_en, m_evt;
    bit           m_run;

    always #(CLK_PERIOD/2) clk = ~clk;

    status_group #(.WIDTH(W)) u_dut (
        .clk (clk), .rst_n (rst_n), .cond_in (cond_in), .dev_rst (dev_rst),
        .clr_stat (clr_stat), .wr_en (wr_en), .rd_en (rd_en), .addr (addr),
        .wdata (wdata), .rdata (rdata), .summary (summary)
    );

    function automatic logic [W-1:0] model_read(input logic [2:0] a);
        case (a)
            3'd0:    return m_cq;
            3'd1:    return m_evt;
            3'd2:    return m_en;
            3'd3:    return m_ptr;
            3'd4:    return m_ntr;
            default: return '0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the following negedge
    task automatic step(input logic [W-1:0] ci, input bit rd, input bit wr,
                        input logic [2:0] a, input logic [W-1:0] wd,
                        input bit clr, input bit drst, input string tag);
        logic [W-1:0] rise, fall, hit, n_cq, n_pq, n_ptr, n_ntr, n_en, n_evt;
        bit n_run;
        cond_in = ci; rd_en = rd; wr_en = wr; addr = a; wdata = wd;
        clr_stat = clr; dev_rst = drst;
        #1;
        if (rd) check(tag, rdata, model_read(a));
        check("R10", {7'b0, summary}, {7'b0, |(m_evt & m_en)});
        rise = m_run ? (m_cq & ~m_pq) : '0;
        fall = m_run ? (~m_cq & m_pq) : '0;
        hit  = (rise & m_ptr) | (fall & m_ntr);
        n_ptr = m_ptr; n_ntr = m_ntr; n_en = m_en;
        if (!m_run) begin n_cq = ci; n_pq = ci; end
        else begin n_cq = ci; n_pq = m_cq; end
        if (drst) begin
            n_evt = '0; n_en = '0; n_ptr = '1; n_ntr = '0; n_run = 0;
        end else begin
            n_run = 1;
            n_evt = ((clr || (rd && a == 3'd1)) ? '0 : m_evt) | hit;
            if (wr) begin
                if (a == 3'd2) n_en  = wd;
                if (a == 3'd3) n_ptr = wd;
                if (a == 3'd4) n_ntr = wd;
            end
        end
        @(posedge clk);
        @(negedge clk);
        m_cq = n_cq; m_pq = n_pq; m_ptr = n_ptr; m_ntr = n_ntr;
        m_en = n_en; m_evt = n_evt; m_run = n_run;
    endtask

    task automatic idle(input logic [W-1:0] ci);
        step(ci, 0, 0, 3'd0, '0, 0, 0, "R10");
    endtask
    task automatic rd(input logic [W-1:0] ci, input logic [2:0] a, input string tag);
        step(ci, 1, 0, a, '0, 0, 0, tag);
    endtask
    task automatic wr(input logic [W-1:0] ci, input logic [2:0] a, input logic [W-1:0] d);
        step(ci, 0, 1, a, d, 0, 0, "R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=%0d exp=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [W-1:0] cur;
        int seed_init;
        seed_init = $urandom(32'h1d5e_ed01);
        rst_n = 0; cond_in = '0; dev_rst = 0; clr_stat = 0; wr_en = 0; rd_en = 0;
        addr = '0; wdata = '0;
        m_cq = '0; m_pq = '0; m_ptr = '1; m_ntr = '0; m_en = '0; m_evt = '0; m_run = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: defaults and the unused addresses
        for (int a = 0; a < 8; a++) rd('0, 3'(a), "R1");
        check("R1", rdata, '0);
        // R12: repeated reads do not disturb state
        rd('0, 3'd3, "R12"); rd('0, 3'd3, "R12"); rd('0, 3'd0, "R12");

        // R2: rising edge timing, two edges after the drive
        wr('0, 3'd2, 8'hFF);
        idle(8'h01);
        rd(8'h01, 3'd1, "R2");           // not yet latched: reads 0
        rd(8'h01, 3'd1, "R2");           // now set
        rd(8'h01, 3'd1, "R6");           // destructive: cleared

        // R3: falling edge
        wr(8'h01, 3'd4, 8'h02);
        idle(8'h03); idle(8'h01); idle(8'h01);
        rd(8'h01, 3'd1, "R3");
        idle(8'h00); idle(8'h00);
        rd(8'h00, 3'd1, "R3");

        // R4: lanes armed both / rise / fall / none
        wr('0, 3'd3, 8'hF0);
        wr('0, 3'd4, 8'hCC);
        idle(8'hFF); idle(8'hFF);
        rd(8'hFF, 3'd1, "R4");
        idle(8'h00); idle(8'h00);
        rd(8'h00, 3'd1, "R4");

        // R5: stickiness with repeated edges
        idle(8'h10); idle(8'h00); idle(8'h10); idle(8'h00); idle(8'h00);
        rd(8'h00, 3'd1, "R5");
        rd(8'h00, 3'd1, "R5");

        // R7: clear-status keeps masks and enable
        wr('0, 3'd2, 8'h5A);
        idle(8'hF0); idle(8'hF0);
        step(8'hF0, 0, 0, 3'd0, '0, 1, 0, "R7");
        rd(8'hF0, 3'd1, "R7"); rd(8'hF0, 3'd2, "R7");
        rd(8'hF0, 3'd3, "R7"); rd(8'hF0, 3'd4, "R7");

        // R8: edge coincides with clear-status, then with an event read
        idle(8'h00);
        step(8'h00, 0, 0, 3'd0, '0, 1, 0, "R8");
        rd(8'h00, 3'd1, "R8");
        idle(8'h10);
        rd(8'h10, 3'd1, "R8");
        rd(8'h10, 3'd1, "R8");

        // R9: writes to read-only addresses
        idle(8'h30); idle(8'h30);
        step(8'h30, 0, 1, 3'd1, 8'h00, 0, 0, "R9");
        step(8'h30, 0, 1, 3'd0, 8'hFF, 0, 0, "R9");
        rd(8'h30, 3'd0, "R9"); rd(8'h30, 3'd1, "R9");
        rd(8'h30, 3'd2, "R9"); rd(8'h30, 3'd3, "R9"); rd(8'h30, 3'd4, "R9");

        // R11: device reset with all inputs high
        wr(8'h30, 3'd2, 8'hFF);
        step(8'hFF, 0, 0, 3'd0, '0, 0, 1, "R11");
        idle(8'hFF); idle(8'hFF); idle(8'hFF);
        for (int a = 1; a < 5; a++) rd(8'hFF, 3'(a), "R11");
        check("R11", {7'b0, summary}, 8'h00);

        // random mix
        cur = 8'hFF;
        for (int i = 0; i < 1500; i++) begin
            int r;
            bit rdv, wrv, clv, drv;
            logic [2:0] av;
            r = $urandom_range(0, 99);
            cur = cur ^ (8'($urandom) & 8'($urandom));
            rdv = (r < 35);
            wrv = (r >= 35 && r < 50);
            clv = (r >= 50 && r < 55);
            drv = (r == 99);
            av  = 3'($urandom_range(0, 7));
            step(cur, rdv, wrv, av, 8'($urandom), clv, drv,
                 (av == 3'd1) ? "R6" : "R12");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule